// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block chooses which local interrupt a hart should take next. It keeps the pending-interrupt register, which is written through a masked update port. It combines that register with the per-line enable vector, the delegation mask, the current privilege level and the global enable bits. From these it produces a registered decision: whether an interrupt is to be taken, its cause index, and whether the trap must go to the hypervisor-level supervisor.

Delegated lines are gated by the supervisor global enable. Lines that are not delegated are gated by the machine global enable. Each global enable takes the current privilege level into account. When guests run under virtualization, hypervisor-level interrupts are checked first. If none can be taken, the guest interrupt bits move down one position and are arbitrated in their place.

A claim register records which interrupt lines already have an owner. A claim that overlaps a line already owned is refused as a whole.

Top module: `irq_prio_select`

## Requirements
- R1: The candidate set is `pend_q & irq_en`. The winner is the lowest-numbered bit of the gated set. `sel_valid`, `sel_cause` and `sel_force_hs` are registered, so they reflect the pending register and the control inputs as they stood at the previous clock edge.
- R2: Lines not delegated (`deleg` bit 0) are allowed when `priv` is below machine (3), or when `priv` is machine and `m_gie` is 1. Privilege codes are user = 0, supervisor = 1, machine = 3.
- R3: Delegated lines (`deleg` bit 1) are allowed when `priv` is user (0), or when `priv` is supervisor (1) and `s_gie` is 1.
- R4: When `virt_on` is 1, the non-guest candidates are gated first by the hypervisor supervisor enable. That enable is true when `priv` is 0, or when `priv` is 1 and `hs_sie` is 1. If any gated candidate remains, the lowest one wins with `sel_force_hs` = 1, regardless of delegation.
- R5: The guest bits are 2, 6 and 10. They are never candidates when `virt_on` is 0. When `virt_on` is 1 and no winner exists under R4, the guest candidates are shifted right by one (to 1, 5 and 9). They then pass the gating of R2 and R3, and `sel_force_hs` is 0.
- R6: When no candidate survives the gating, `sel_valid`, `sel_cause` and `sel_force_hs` are all 0.
- R7: A pending write (`pw_en` = 1) sets `pend_q` to `(pend_q & ~pw_mask) | (pw_data & pw_mask)` at the clock edge, and `pend_old` takes the value `pend_q` had before that write. With `pw_en` = 0, `pend_q` is held.
- R8: `irq_req` is 1 exactly when `pend_q` is nonzero.
- R9: A claim (`cl_req` = 1) is refused when `cl_bits & claim_q` is nonzero. In that case `claim_q` is unchanged and `cl_ok` is 0. Otherwise `cl_bits` is ORed into `claim_q` and `cl_ok` is 1. `cl_done` pulses for one cycle after each claim, and claimed bits are never released.
- R10: After reset, `pend_q`, `pend_old`, `claim_q` and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_en | input | 1 | Pending write strobe |
| pw_mask | input | N_IRQ | Bits to be replaced |
| pw_data | input | N_IRQ | New values for masked bits |
| pend_q | output | N_IRQ | Pending register |
| pend_old | output | N_IRQ | Pending value before the last write |
| irq_req | output | 1 | Pending register is nonzero |
| irq_en | input | N_IRQ | Per-line enables |
| deleg | input | N_IRQ | Delegation to supervisor |
| priv | input | 2 | Current privilege level |
| m_gie | input | 1 | Machine global enable |
| s_gie | input | 1 | Supervisor global enable |
| virt_on | input | 1 | Virtualization active |
| hs_sie | input | 1 | Saved hypervisor supervisor enable |
| sel_valid | output | 1 | An interrupt is to be taken |
| sel_cause | output | CAUSE_W | Winning cause index |
| sel_force_hs | output | 1 | Trap goes to hypervisor supervisor |
| cl_req | input | 1 | Claim strobe |
| cl_bits | input | N_IRQ | Lines to claim |
| cl_done | output | 1 | Claim result is valid |
| cl_ok | output | 1 | Claim accepted |
| claim_q | output | N_IRQ | Claimed lines |

## Verification
A corrupted pending register appears on `pend_q` and `irq_req` in the same cycle. It reaches the selection outputs one edge later as a wrong cause or a wrong valid flag. A wrong gating term, such as a misread privilege or a missed delegation bit, shows up only as a wrong cause on the cycle after the inputs that expose it. The stimulus therefore sweeps every privilege level, both virtualization states and random delegation masks. A claim register that loses or gains bits is visible on `claim_q` at once, and on the next overlapping claim it gives a wrong accept or refuse.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // guest software / timer / external interrupt positions
  localparam int GUEST_SW  = 2;
  localparam int GUEST_TMR = 6;
  localparam int GUEST_EXT = 10;
  localparam int GUEST_MIN_WIDTH = GUEST_EXT + 1;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_IRQ   = 16,
  parameter int CAUSE_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]   vec,
  output logic               any,
  output logic [CAUSE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (vec[i]) idx = CAUSE_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_IRQ-1:0] wr_mask,
  input  logic [N_IRQ-1:0] wr_data,
  output logic [N_IRQ-1:0] pend,
  output logic [N_IRQ-1:0] pend_prev
);
  logic [N_IRQ-1:0] pend_d;

  always_comb begin
    pend_d = (pend & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_prev <= '0;
    end else if (wr_en) begin
      pend      <= pend_d;
      pend_prev <= pend;
    end
  end
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
  parameter int N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [N_IRQ-1:0] bits,
  output logic [N_IRQ-1:0] owned,
  output logic             done,
  output logic             ok
);
  logic             clash;
  logic [N_IRQ-1:0] owned_d;

  always_comb begin
    clash   = |(owned & bits);
    owned_d = owned;
    if (req && !clash) owned_d = owned | bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned <= '0;
      done  <= 1'b0;
      ok    <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        owned <= owned_d;
        ok    <= !clash;
      end
    end
  end
endmodule

// File: rtl/irq_gate_arb.sv
module irq_gate_arb
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ   = 16,
  parameter int CAUSE_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]   pend,
  input  logic [N_IRQ-1:0]   en,
  input  logic [N_IRQ-1:0]   deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  input  logic               virt_on,
  input  logic               hs_sie,
  output logic               valid,
  output logic [CAUSE_W-1:0] cause,
  output logic               force_hs
);
  logic [N_IRQ-1:0] guest_mask;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_gmask
    assign guest_mask[g] = (g == GUEST_SW) || (g == GUEST_TMR) || (g == GUEST_EXT);
  end

  logic [N_IRQ-1:0] cand, host_cand, guest_sh, hs_set, base, gated;
  logic             mach_ok, sup_ok, hs_ok;
  logic             hs_any, fin_any;
  logic [CAUSE_W-1:0] hs_idx, fin_idx;

  always_comb begin
    cand      = pend & en;
    host_cand = cand & ~guest_mask;
    guest_sh  = (cand & guest_mask) >> 1;
    mach_ok   = (priv != PRIV_MACH) || m_gie;
    sup_ok    = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_gie);
    hs_ok     = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && hs_sie);
    hs_set    = (virt_on && hs_ok) ? host_cand : '0;
    base      = virt_on ? guest_sh : host_cand;
    gated     = (base & ~deleg & {N_IRQ{mach_ok}}) |
                (base & deleg & {N_IRQ{sup_ok}});
  end

  irq_lowest_pick #(.N_IRQ(N_IRQ), .CAUSE_W(CAUSE_W)) u_pick_hs (
    .vec(hs_set), .any(hs_any), .idx(hs_idx)
  );

  irq_lowest_pick #(.N_IRQ(N_IRQ), .CAUSE_W(CAUSE_W)) u_pick_fin (
    .vec(gated), .any(fin_any), .idx(fin_idx)
  );

  always_comb begin
    if (hs_any) begin
      valid    = 1'b1;
      cause    = hs_idx;
      force_hs = 1'b1;
    end else begin
      valid    = fin_any;
      cause    = fin_idx;
      force_hs = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ   = 16,
  parameter int CAUSE_W = $clog2(N_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pw_en,
  input  logic [N_IRQ-1:0]   pw_mask,
  input  logic [N_IRQ-1:0]   pw_data,
  output logic [N_IRQ-1:0]   pend_q,
  output logic [N_IRQ-1:0]   pend_old,
  output logic               irq_req,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic [N_IRQ-1:0]   deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  input  logic               virt_on,
  input  logic               hs_sie,
  output logic               sel_valid,
  output logic [CAUSE_W-1:0] sel_cause,
  output logic               sel_force_hs,
  input  logic               cl_req,
  input  logic [N_IRQ-1:0]   cl_bits,
  output logic               cl_done,
  output logic               cl_ok,
  output logic [N_IRQ-1:0]   claim_q
);
  if (N_IRQ < GUEST_MIN_WIDTH) begin : g_bad_width
    initial $error("N_IRQ too small for guest interrupt positions");
  end

  irq_pend_reg #(.N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(pw_en), .wr_mask(pw_mask),
    .wr_data(pw_data), .pend(pend_q), .pend_prev(pend_old)
  );

  assign irq_req = |pend_q;

  irq_claim_reg #(.N_IRQ(N_IRQ)) u_claim (
    .clk(clk), .rst_n(rst_n), .req(cl_req), .bits(cl_bits),
    .owned(claim_q), .done(cl_done), .ok(cl_ok)
  );

  logic               arb_valid, arb_force;
  logic [CAUSE_W-1:0] arb_cause;

  irq_gate_arb #(.N_IRQ(N_IRQ), .CAUSE_W(CAUSE_W)) u_arb (
    .pend(pend_q), .en(irq_en), .deleg(deleg), .priv(priv),
    .m_gie(m_gie), .s_gie(s_gie), .virt_on(virt_on), .hs_sie(hs_sie),
    .valid(arb_valid), .cause(arb_cause), .force_hs(arb_force)
  );

  logic               valid_d, force_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    valid_d = arb_valid;
    force_d = arb_valid && arb_force;
    cause_d = arb_valid ? arb_cause : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid    <= 1'b0;
      sel_cause    <= '0;
      sel_force_hs <= 1'b0;
    end else begin
      sel_valid    <= valid_d;
      sel_cause    <= cause_d;
      sel_force_hs <= force_d;
    end
  end
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
  parameter int N_IRQ   = 16,
  parameter int CAUSE_W = $clog2(N_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pw_en,
  input logic [N_IRQ-1:0]   pw_mask,
  input logic [N_IRQ-1:0]   pw_data,
  input logic [N_IRQ-1:0]   pend_q,
  input logic [N_IRQ-1:0]   pend_old,
  input logic               irq_req,
  input logic               virt_on,
  input logic               sel_valid,
  input logic [CAUSE_W-1:0] sel_cause,
  input logic               sel_force_hs,
  input logic               cl_req,
  input logic [N_IRQ-1:0]   cl_bits,
  input logic               cl_done,
  input logic               cl_ok,
  input logic [N_IRQ-1:0]   claim_q
);
  a_r7_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    pw_en |=> pend_q == (($past(pend_q) & ~$past(pw_mask)) | ($past(pw_data) & $past(pw_mask))));

  a_r7_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    pw_en |=> pend_old == $past(pend_q));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_en |=> $stable(pend_q));

  always_comb begin
    if (rst_n) a_r8_req_level: assert (irq_req == (pend_q != '0));
  end

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_cause == '0) && !sel_force_hs);

  a_r4_force_needs_virt: assert property (@(posedge clk) disable iff (!rst_n)
    sel_force_hs |-> $past(virt_on));

  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_req && ((cl_bits & claim_q) != '0)) |=> !cl_ok && $stable(claim_q));

  a_r9_never_release: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(claim_q) & ~claim_q) == '0));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cl_req |=> cl_done);
endmodule

bind irq_prio_select irq_prio_select_chk #(.N_IRQ(N_IRQ), .CAUSE_W(CAUSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pw_en(pw_en), .pw_mask(pw_mask), .pw_data(pw_data),
  .pend_q(pend_q), .pend_old(pend_old), .irq_req(irq_req), .virt_on(virt_on),
  .sel_valid(sel_valid), .sel_cause(sel_cause), .sel_force_hs(sel_force_hs),
  .cl_req(cl_req), .cl_bits(cl_bits), .cl_done(cl_done), .cl_ok(cl_ok),
  .claim_q(claim_q)
);

// File: tb/irq_prio_select_tb.sv
module irq_prio_select_tb_top;
  localparam int N  = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pw_en = 1'b0;
  logic [N-1:0]  pw_mask = '0, pw_data = '0, pend_q, pend_old;
  logic          irq_req;
  logic [N-1:0]  irq_en = '0, deleg = '0;
  logic [1:0]    priv = 2'd3;
  logic          m_gie = 1'b0, s_gie = 1'b0, virt_on = 1'b0, hs_sie = 1'b0;
  logic          sel_valid, sel_force_hs;
  logic [CW-1:0] sel_cause;
  logic          cl_req = 1'b0;
  logic [N-1:0]  cl_bits = '0;
  logic          cl_done, cl_ok;
  logic [N-1:0]  claim_q;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_claim = '0;

  always #2.5 clk = ~clk;

  irq_prio_select #(.N_IRQ(N), .CAUSE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pw_en(pw_en), .pw_mask(pw_mask), .pw_data(pw_data),
    .pend_q(pend_q), .pend_old(pend_old), .irq_req(irq_req), .irq_en(irq_en),
    .deleg(deleg), .priv(priv), .m_gie(m_gie), .s_gie(s_gie), .virt_on(virt_on),
    .hs_sie(hs_sie), .sel_valid(sel_valid), .sel_cause(sel_cause),
    .sel_force_hs(sel_force_hs), .cl_req(cl_req), .cl_bits(cl_bits),
    .cl_done(cl_done), .cl_ok(cl_ok), .claim_q(claim_q)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {force, valid, cause}
  function automatic logic [5:0] model(input logic [N-1:0] p);
    logic [N-1:0] c, host, gsh, base, g;
    logic mo, so, ho;
    logic [N-1:0] gm;
    gm = '0; gm[2] = 1'b1; gm[6] = 1'b1; gm[10] = 1'b1;
    c = p & irq_en;
    host = c & ~gm;
    gsh = (c & gm) >> 1;
    mo = (priv < 2'd3) || m_gie;
    so = (priv == 2'd0) || (priv == 2'd1 && s_gie);
    ho = (priv == 2'd0) || (priv == 2'd1 && hs_sie);
    if (virt_on && ho && host != '0) begin
      for (int i = N - 1; i >= 0; i--) if (host[i]) model = {1'b1, 1'b1, 4'(i)};
      return model;
    end
    base = virt_on ? gsh : host;
    g = (base & ~deleg & {N{mo}}) | (base & deleg & {N{so}});
    model = 6'd0;
    for (int i = N - 1; i >= 0; i--) if (g[i]) model = {1'b0, 1'b1, 4'(i)};
  endfunction

  // write pending, wait for selection, check both
  task automatic step(input logic [N-1:0] msk, input logic [N-1:0] dat, input string req);
    logic [N-1:0] old;
    logic [5:0] e;
    old = m_pend;
    pw_en = 1'b1; pw_mask = msk; pw_data = dat;
    @(posedge clk); #1;
    pw_en = 1'b0;
    m_pend = (old & ~msk) | (dat & msk);
    chk(pend_q == m_pend, "R7 pend", 32'(pend_q), 32'(m_pend));
    chk(pend_old == old, "R7 old", 32'(pend_old), 32'(old));
    chk(irq_req == (m_pend != '0), "R8 req", 32'(irq_req), 32'(m_pend != '0));
    @(posedge clk); #1;
    e = model(m_pend);
    chk({sel_force_hs, sel_valid, sel_cause} == e, req,
        32'({sel_force_hs, sel_valid, sel_cause}), 32'(e));
  endtask

  task automatic claim(input logic [N-1:0] b);
    logic okx;
    okx = (b & m_claim) == '0;
    cl_req = 1'b1; cl_bits = b;
    @(posedge clk); #1;
    cl_req = 1'b0;
    if (okx) m_claim = m_claim | b;
    chk(cl_done && cl_ok == okx, "R9 claim result", 32'({cl_done, cl_ok}), 32'({1'b1, okx}));
    chk(claim_q == m_claim, "R9 claim reg", 32'(claim_q), 32'(m_claim));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(pend_q == '0 && pend_old == '0 && claim_q == '0, "R10 regs", 32'(pend_q | claim_q), 0);
    chk(!sel_valid && !irq_req && !cl_done && !cl_ok, "R10 flags", 32'({sel_valid, irq_req, cl_done, cl_ok}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 lowest wins, machine mode with enable
    irq_en = '1; deleg = '0; priv = 2'd3; m_gie = 1'b1;
    step(16'hffff, 16'h0880, "R1 lowest wins");
    // R2 machine mode without enable -> nothing
    m_gie = 1'b0;
    step(16'h0000, 16'h0000, "R2 machine disabled");
    // R2 below machine: always enabled
    priv = 2'd1;
    step(16'h0000, 16'h0000, "R2 supervisor takes machine line");
    // R3 delegated in machine mode: blocked
    deleg = 16'h0880; priv = 2'd3; m_gie = 1'b1;
    step(16'h0000, 16'h0000, "R3 delegated blocked in machine");
    // R3 delegated in supervisor with s_gie
    priv = 2'd1; s_gie = 1'b1;
    step(16'h0000, 16'h0000, "R3 supervisor enabled");
    s_gie = 1'b0;
    step(16'h0000, 16'h0000, "R3 supervisor disabled");
    // R5 guest bit ignored without virt
    deleg = '0; priv = 2'd3; m_gie = 1'b1;
    step(16'hffff, 16'h0004, "R5 guest ignored no virt");
    // R5 shift under virt: bit 2 -> cause 1
    virt_on = 1'b1; priv = 2'd0;
    step(16'h0000, 16'h0000, "R5 guest shifted");
    // R4 host line wins with force
    step(16'h0100, 16'h0100, "R4 hs priority");
    // R4 hs enable off in supervisor -> falls to guest arbitration
    priv = 2'd1; hs_sie = 1'b0; s_gie = 1'b1;
    step(16'h0000, 16'h0000, "R4 hs disabled");
    // R6 nothing pending
    virt_on = 1'b0;
    step(16'hffff, 16'h0000, "R6 none");

    // random
    for (int k = 0; k < 300; k++) begin
      irq_en  = N'($urandom);
      deleg   = N'($urandom);
      priv    = 2'($urandom);
      m_gie   = 1'($urandom);
      s_gie   = 1'($urandom);
      virt_on = 1'($urandom);
      hs_sie  = 1'($urandom);
      step(N'($urandom), N'($urandom), "R1 random select");
    end

    // R9 claims
    claim(16'h000f);
    claim(16'h0030);
    claim(16'h0101);
    claim(16'h8000);
    for (int k = 0; k < 20; k++) claim(N'(1) << ($urandom % N));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule